// File: doc/BRIEF.md
# Quad-Word Link DMA Channel Pair

This block moves 128-bit quad-words between a single-ported synchronous memory and the two buffers of one point-to-point link port. It has a transmit engine and a receive engine. They are independent and may run at the same time. The transmit engine reads quad-words from memory into the outgoing link buffer. The receive engine writes each quad-word that the link has placed in the incoming buffer out to memory.

Software starts a direction by writing one 128-bit descriptor to it. The descriptor gives the start address, a transfer count, a signed address step and the control bits. The engine then walks the address and count down on its own. When the count is used up it turns itself off and, if asked to, pulses an interrupt for one clock.

A descriptor with the enable bit set is accepted only while that direction is idle. A descriptor with the enable bit clear stops the direction at once. Both engines share the memory port through an arbiter that alternates between them under contention.

Top module: `lqdma_pair`

## Requirements
- R1: After reset both directions are inactive. No memory access is made. The outgoing buffer is empty, no receive pop is issued and both interrupts are low.
- R2: Descriptor field positions within the 128-bit descriptor are as follows:
  - bits 31:0: start quad-word address, of which the low AW bits are used.
  - bits 63:48: transfer count.
  - bits 47:32: signed address step.
  - bits 95:80: second-dimension count.
  - bit 96: enable.
  - bit 97: interrupt enable.
  - All other bits are ignored.
- R3: An enabled transmit descriptor reads `count` quad-words from the start address. The address advances by the sign-extended step after each read. Each quad-word appears on the outgoing buffer in address order. No read is issued while the outgoing buffer holds a quad-word that the link has not yet taken.
- R4: While the receive direction is active and the incoming buffer is full, the block writes that quad-word to the current address. It asserts the pop output in the same cycle. Successive writes follow start address plus multiples of the signed step.
- R5: Both directions may be active together. The memory port carries at most one access per cycle. When both directions request in the same cycle, the grant alternates between them.
- R6: A direction goes inactive in the cycle after its last memory access. It then makes no further memory access.
- R7: On completion, the interrupt output of that direction is high for exactly one clock if interrupt enable was set, and stays low otherwise.
- R8: A descriptor with a zero transfer count and the enable bit set makes no memory access and leaves the direction inactive. When interrupt enable is set, it raises the interrupt in the clock after the load.
- R9: An enabled descriptor written while its direction is active is ignored. The running transfer continues with its original address and count.
- R10: A descriptor with the enable bit clear stops its direction in the next cycle. No further access follows and no interrupt is raised.
- R11: An enabled descriptor whose second-dimension count is nonzero is refused. The direction stays inactive and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_desc_we | input | 1 | Write desc_data as the transmit descriptor |
| rx_desc_we | input | 1 | Write desc_data as the receive descriptor |
| desc_data | input | 128 | Descriptor value |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write (receive) |
| mem_addr | output | AW | Quad-word address |
| mem_wdata | output | 128 | Write data |
| mem_rdata | input | 128 | Read data, valid the cycle after a read |
| txb_valid | output | 1 | Outgoing buffer holds a quad-word |
| txb_data | output | 128 | Outgoing buffer contents |
| txb_take | input | 1 | Link takes the outgoing quad-word |
| rxb_valid | input | 1 | Incoming buffer is full |
| rxb_data | input | 128 | Incoming buffer contents |
| rxb_pop | output | 1 | Incoming quad-word consumed this cycle |
| tx_active | output | 1 | Transmit direction running |
| rx_active | output | 1 | Receive direction running |
| tx_irq | output | 1 | Transmit completion pulse |
| rx_irq | output | 1 | Receive completion pulse |

## Verification
The hardest state to reach from the ports is a running transfer that receives a second enabled descriptor while it is active. The stimulus starts a receive transfer and withholds incoming data, so the channel sits active with its count untouched. A conflicting descriptor is then written, and the data is fed in afterwards. The writes must land at the first descriptor's addresses, and the transfer must stop after the first descriptor's count. A similar stall is built on the transmit side by not taking the outgoing buffer, which shows that reads stop while the buffer is full. The stop descriptor is applied in the middle of a receive stream, and a further incoming quad-word must then stay unconsumed.

// File: rtl/lqdma_pkg.sv
package lqdma_pkg;
   localparam int QW_W  = 128;
   localparam int CNT_W = 16;
   localparam int STP_W = 16;
   localparam int CTL_EN  = 0;
   localparam int CTL_IEN = 1;

   typedef struct packed {
      logic [31:0] ctl;
      logic [31:0] ywd;
      logic [31:0] xwd;
      logic [31:0] base;
   } lq_desc_t;
endpackage

// File: rtl/lqdma_seq.sv
module lqdma_seq
   import lqdma_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          desc_we,
   input  lq_desc_t      desc_i,
   input  logic          step,
   output logic          active,
   output logic [AW-1:0] addr,
   output logic          irq
);
   if (AW < 4 || AW > 32) begin : g_bad_aw
      $error("lqdma_seq: AW must lie in 4..32");
   end

   logic             active_q, ien_q, irq_q;
   logic [AW-1:0]    addr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [STP_W-1:0] stp_q;

   logic             want_on, flat_ok, take_on, stop_now, last_step;
   logic [CNT_W-1:0] new_cnt;
   logic [AW-1:0]    stp_ext;

   assign want_on   = desc_i.ctl[CTL_EN];
   assign flat_ok   = (desc_i.ywd[31:16] == '0);
   assign take_on   = desc_we && want_on && !active_q && flat_ok;
   assign stop_now  = desc_we && !want_on;
   assign last_step = step && (cnt_q == CNT_W'(1));
   assign new_cnt   = desc_i.xwd[31:16];
   assign stp_ext   = AW'($signed(stp_q));

   logic unused_fields;
   assign unused_fields = ^{desc_i.ywd[15:0], desc_i.ctl[31:2], desc_i.base};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ien_q    <= 1'b0;
         irq_q    <= 1'b0;
         addr_q   <= '0;
         cnt_q    <= '0;
         stp_q    <= '0;
      end else begin
         irq_q <= 1'b0;
         if (stop_now) begin
            active_q <= 1'b0;
         end else if (take_on) begin
            addr_q <= desc_i.base[AW-1:0];
            cnt_q  <= new_cnt;
            stp_q  <= desc_i.xwd[15:0];
            ien_q  <= desc_i.ctl[CTL_IEN];
            if (new_cnt == '0) begin
               irq_q <= desc_i.ctl[CTL_IEN];
            end else begin
               active_q <= 1'b1;
            end
         end else if (step) begin
            addr_q <= addr_q + stp_ext;
            cnt_q  <= cnt_q - CNT_W'(1);
            if (last_step) begin
               active_q <= 1'b0;
               irq_q    <= ien_q;
            end
         end
      end
   end

   assign active = active_q;
   assign addr   = addr_q;
   assign irq    = irq_q;

   assert_idle_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> !step);
   assert_irq_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> !active_q);
   assert_guard_keeps_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && desc_we && want_on && !last_step) |=> active_q);
   assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_now |=> (!active_q && !irq_q));
endmodule

// File: rtl/lqdma_engine.sv
module lqdma_engine
   import lqdma_pkg::*;
#(
   parameter int AW    = 16,
   parameter bit IS_RX = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            desc_we,
   input  lq_desc_t        desc_i,
   input  logic            mem_gnt,
   input  logic [QW_W-1:0] mem_rdata,
   input  logic            lk_in_valid,
   input  logic [QW_W-1:0] lk_in_data,
   input  logic            lk_take,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   output logic [QW_W-1:0] mem_wdata,
   output logic            lk_pop,
   output logic            buf_valid,
   output logic [QW_W-1:0] buf_data,
   output logic            active,
   output logic            irq
);
   logic run;

   lqdma_seq #(.AW(AW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .desc_we (desc_we),
      .desc_i  (desc_i),
      .step    (mem_gnt),
      .active  (run),
      .addr    (mem_addr),
      .irq     (irq)
   );

   assign active = run;

   if (IS_RX) begin : g_rx
      assign mem_req   = run && lk_in_valid;
      assign mem_wdata = lk_in_data;
      assign lk_pop    = mem_gnt;
      assign buf_valid = 1'b0;
      assign buf_data  = '0;

      logic unused_rx_side;
      assign unused_rx_side = ^{mem_rdata, lk_take};

      assert_pop_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
         lk_pop |-> lk_in_valid);
   end else begin : g_tx
      logic            full_q, pend_q;
      logic [QW_W-1:0] hold_q;

      assign mem_req   = run && !full_q && !pend_q;
      assign mem_wdata = '0;
      assign lk_pop    = 1'b0;
      assign buf_valid = full_q;
      assign buf_data  = hold_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            full_q <= 1'b0;
            pend_q <= 1'b0;
            hold_q <= '0;
         end else begin
            pend_q <= mem_gnt;
            if (pend_q) begin
               hold_q <= mem_rdata;
               full_q <= 1'b1;
            end else if (lk_take) begin
               full_q <= 1'b0;
            end
         end
      end

      logic unused_tx_side;
      assign unused_tx_side = ^{lk_in_valid, lk_in_data};

      assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
         pend_q |-> !full_q);
   end
endmodule

// File: rtl/lqdma_arb.sv
module lqdma_arb #(
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_a,
   input  logic req_b,
   output logic gnt_a,
   output logic gnt_b
);
   if (ROUND_ROBIN) begin : g_rr
      logic last_a_q;
      assign gnt_b = req_b && (!req_a || last_a_q);
      assign gnt_a = req_a && !gnt_b;

      always_ff @(posedge clk) begin
         if (!rst_n)      last_a_q <= 1'b0;
         else if (gnt_a)  last_a_q <= 1'b1;
         else if (gnt_b)  last_a_q <= 1'b0;
      end

      assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (req_a && req_b && $past(req_a && req_b)) |-> (gnt_a != $past(gnt_a)));
   end else begin : g_fixed
      assign gnt_b = req_b;
      assign gnt_a = req_a && !req_b;
   end

   assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_a, gnt_b}) && (!gnt_a || req_a) && (!gnt_b || req_b));
endmodule

// File: rtl/lqdma_pair.sv
module lqdma_pair
   import lqdma_pkg::*;
#(
   parameter int AW          = 16,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tx_desc_we,
   input  logic            rx_desc_we,
   input  logic [127:0]    desc_data,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [127:0]    mem_wdata,
   input  logic [127:0]    mem_rdata,
   output logic            txb_valid,
   output logic [127:0]    txb_data,
   input  logic            txb_take,
   input  logic            rxb_valid,
   input  logic [127:0]    rxb_data,
   output logic            rxb_pop,
   output logic            tx_active,
   output logic            rx_active,
   output logic            tx_irq,
   output logic            rx_irq
);
   lq_desc_t        dsc;
   logic            tx_req, rx_req, tx_gnt, rx_gnt;
   logic [AW-1:0]   tx_addr, rx_addr;
   logic [QW_W-1:0] tx_wd, rx_wd, rx_bufd;
   logic            tx_pop, rx_bufv;

   assign dsc = desc_data;

   lqdma_engine #(.AW(AW), .IS_RX(1'b0)) u_tx (
      .clk (clk), .rst_n (rst_n), .desc_we (tx_desc_we), .desc_i (dsc),
      .mem_gnt (tx_gnt), .mem_rdata (mem_rdata),
      .lk_in_valid (1'b0), .lk_in_data ('0), .lk_take (txb_take),
      .mem_req (tx_req), .mem_addr (tx_addr), .mem_wdata (tx_wd),
      .lk_pop (tx_pop), .buf_valid (txb_valid), .buf_data (txb_data),
      .active (tx_active), .irq (tx_irq)
   );

   lqdma_engine #(.AW(AW), .IS_RX(1'b1)) u_rx (
      .clk (clk), .rst_n (rst_n), .desc_we (rx_desc_we), .desc_i (dsc),
      .mem_gnt (rx_gnt), .mem_rdata (mem_rdata),
      .lk_in_valid (rxb_valid), .lk_in_data (rxb_data), .lk_take (1'b0),
      .mem_req (rx_req), .mem_addr (rx_addr), .mem_wdata (rx_wd),
      .lk_pop (rxb_pop), .buf_valid (rx_bufv), .buf_data (rx_bufd),
      .active (rx_active), .irq (rx_irq)
   );

   lqdma_arb #(.ROUND_ROBIN(ROUND_ROBIN)) u_arb (
      .clk (clk), .rst_n (rst_n),
      .req_a (tx_req), .req_b (rx_req),
      .gnt_a (tx_gnt), .gnt_b (rx_gnt)
   );

   assign mem_req   = tx_gnt || rx_gnt;
   assign mem_we    = rx_gnt;
   assign mem_addr  = rx_gnt ? rx_addr : tx_addr;
   assign mem_wdata = rx_wd;

   logic unused_side;
   assign unused_side = ^{tx_wd, tx_pop, rx_bufv, rx_bufd};

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $past(!rst_n) |-> (!tx_active && !rx_active && !txb_valid && !tx_irq && !rx_irq));
endmodule

// File: tb/lqdma_pair_tb.sv
module lqdma_pair_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tx_desc_we = 1'b0, rx_desc_we = 1'b0;
   logic [127:0] desc_data = '0;
   logic         mem_req, mem_we;
   logic [15:0]  mem_addr;
   logic [127:0] mem_wdata, mem_rdata, txb_data;
   logic         txb_valid, txb_take, rxb_pop;
   logic         rxb_valid;
   logic [127:0] rxb_data;
   logic         tx_active, rx_active, tx_irq, rx_irq;

   always #10 clk = ~clk;

   lqdma_pair u_dut (
      .clk (clk), .rst_n (rst_n), .tx_desc_we (tx_desc_we), .rx_desc_we (rx_desc_we),
      .desc_data (desc_data), .mem_req (mem_req), .mem_we (mem_we),
      .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
      .txb_valid (txb_valid), .txb_data (txb_data), .txb_take (txb_take),
      .rxb_valid (rxb_valid), .rxb_data (rxb_data), .rxb_pop (rxb_pop),
      .tx_active (tx_active), .rx_active (rx_active), .tx_irq (tx_irq), .rx_irq (rx_irq)
   );

   int checks = 0, errors = 0;
   int n_rd = 0, n_wr = 0, n_txi = 0, n_rxi = 0;
   bit both_seen = 0, tx_consume = 1, done = 0;

   logic [127:0] mem [0:255];
   logic [127:0] txq [$];
   logic [127:0] rxq_d [$];
   logic [15:0]  rxq_a [$];
   logic [127:0] feedq [$];

   function automatic logic [127:0] txpat(int i);
      return {32'hA500_0000 + i, 32'h5A00_0000 + i, 32'h1234_0000 + i, 32'h0F0F_0000 + i};
   endfunction
   function automatic logic [127:0] rxpat(int k);
      return {32'hC0DE_0000 + k, 32'hBEEF_0000 + k, 32'h7777_0000 + k, 32'h0000_0100 + k};
   endfunction
   function automatic logic [127:0] mk(int base, int cnt, int stp, int ycnt, bit en, bit ien);
      return {30'b0, ien, en, 16'(ycnt), 16'h0, 16'(cnt), 16'(stp), 32'(base)};
   endfunction

   task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory model: read data one cycle after request
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[7:0]];
      end
   end

   // incoming link buffer model
   always @(posedge clk) begin
      if (!rst_n) rxb_valid <= 1'b0;
      else if (rxb_pop) rxb_valid <= 1'b0;
      else if (!rxb_valid && feedq.size() > 0) begin
         rxb_data  <= feedq.pop_front();
         rxb_valid <= 1'b1;
      end
   end

   // monitors, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && !mem_we) n_rd++;
         if (tx_irq) n_txi++;
         if (rx_irq) n_rxi++;
         if (tx_active && rx_active) both_seen = 1;
         if (mem_req && mem_we) begin
            n_wr++;
            if (rxq_d.size() == 0) chk(0, "R4", "unexpected write", {112'b0, mem_addr}, '0);
            else begin
               logic [127:0] ed;
               logic [15:0]  ea;
               ed = rxq_d.pop_front();
               ea = rxq_a.pop_front();
               chk(mem_addr == ea, "R4", "write address", {112'b0, mem_addr}, {112'b0, ea});
               chk(mem_wdata == ed, "R4", "write data", mem_wdata, ed);
            end
         end
         if (txb_valid && tx_consume) begin
            if (txq.size() == 0) chk(0, "R3", "unexpected outgoing word", txb_data, '0);
            else begin
               logic [127:0] e;
               e = txq.pop_front();
               chk(txb_data == e, "R3", "outgoing word", txb_data, e);
            end
            txb_take = 1'b1;
         end else begin
            txb_take = 1'b0;
         end
      end else begin
         txb_take = 1'b0;
      end
   end

   task automatic load(bit is_rx, logic [127:0] d);
      @(negedge clk);
      desc_data = d;
      if (is_rx) rx_desc_we = 1'b1; else tx_desc_we = 1'b1;
      @(negedge clk);
      tx_desc_we = 1'b0;
      rx_desc_we = 1'b0;
   endtask

   task automatic push_tx(int base, int cnt, int stp);
      for (int i = 0; i < cnt; i++) txq.push_back(mem[8'(base + i * stp)]);
   endtask
   task automatic push_rx(int base, int cnt, int stp, int k0);
      for (int i = 0; i < cnt; i++) begin
         rxq_a.push_back(16'(base + i * stp));
         rxq_d.push_back(rxpat(k0 + i));
         feedq.push_back(rxpat(k0 + i));
      end
   endtask

   task automatic wait_idle(string req);
      int n = 0;
      while ((txq.size() > 0 || rxq_d.size() > 0 || tx_active || rx_active) && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(n < 2000, req, "transfer did not finish", 128'(n), 128'd0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
         $finish;
      end
   end

   initial begin
      int rd0, wr0, ti0, ri0;
      for (int i = 0; i < 256; i++) mem[i] = txpat(i);
      rxb_data = '0;
      mem_rdata = '0;
      repeat (4) @(negedge clk);
      chk(!tx_active && !rx_active && !mem_req && !txb_valid && !rxb_pop && !tx_irq && !rx_irq,
          "R1", "reset state", {tx_active, rx_active, mem_req, txb_valid, tx_irq, rx_irq}, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!tx_active && !mem_req && !txb_valid, "R1", "idle after reset",
          {tx_active, mem_req, txb_valid}, '0);

      // R2 R3 R6 R7: basic transmit, step +1, interrupt on
      rd0 = n_rd; ti0 = n_txi;
      push_tx(16, 4, 1);
      load(0, mk(16, 4, 1, 0, 1, 1));
      wait_idle("R3");
      repeat (10) @(negedge clk);
      chk(n_rd - rd0 == 4, "R6", "tx read count", 128'(n_rd - rd0), 128'd4);
      chk(!tx_active, "R6", "tx inactive after end", 128'(tx_active), 128'd0);
      chk(n_txi - ti0 == 1, "R7", "tx irq pulses", 128'(n_txi - ti0), 128'd1);

      // R3: negative step
      push_tx(40, 3, -2);
      load(0, mk(40, 3, 16'hFFFE, 0, 1, 0));
      wait_idle("R3");
      chk(txq.size() == 0, "R3", "negative step words", 128'(txq.size()), 128'd0);

      // R3: no read while the outgoing buffer is full
      tx_consume = 0;
      rd0 = n_rd;
      push_tx(60, 3, 1);
      load(0, mk(60, 3, 1, 0, 1, 0));
      repeat (20) @(negedge clk);
      chk(n_rd - rd0 == 1, "R3", "reads while buffer full", 128'(n_rd - rd0), 128'd1);
      chk(txb_valid, "R3", "buffer held", 128'(txb_valid), 128'd1);
      tx_consume = 1;
      wait_idle("R3");
      chk(n_rd - rd0 == 3, "R3", "reads after release", 128'(n_rd - rd0), 128'd3);

      // R4 R7: basic receive
      wr0 = n_wr; ri0 = n_rxi;
      push_rx(100, 3, 1, 0);
      load(1, mk(100, 3, 1, 0, 1, 1));
      wait_idle("R4");
      chk(n_wr - wr0 == 3, "R4", "rx write count", 128'(n_wr - wr0), 128'd3);
      chk(n_rxi - ri0 == 1, "R7", "rx irq pulses", 128'(n_rxi - ri0), 128'd1);
      chk(mem[101] == rxpat(1), "R4", "memory after rx", mem[101], rxpat(1));

      // R5 R7: both directions together, tx interrupt off
      ti0 = n_txi; ri0 = n_rxi; both_seen = 0;
      push_tx(0, 4, 1);
      load(0, mk(0, 4, 1, 0, 1, 0));
      push_rx(130, 4, 2, 10);
      load(1, mk(130, 4, 2, 0, 1, 1));
      wait_idle("R5");
      chk(both_seen, "R5", "concurrent activity", 128'(both_seen), 128'd1);
      chk(n_txi - ti0 == 0, "R7", "tx irq with enable clear", 128'(n_txi - ti0), 128'd0);
      chk(n_rxi - ri0 == 1, "R7", "rx irq concurrent", 128'(n_rxi - ri0), 128'd1);

      // R8: zero count
      rd0 = n_rd;
      @(negedge clk);
      desc_data = mk(20, 0, 1, 0, 1, 1);
      tx_desc_we = 1'b1;
      @(negedge clk);
      tx_desc_we = 1'b0;
      chk(tx_irq && !tx_active, "R8", "zero count irq", {tx_irq, tx_active}, 2'b10);
      @(negedge clk);
      chk(!tx_irq, "R8", "zero count irq width", 128'(tx_irq), 128'd0);
      repeat (10) @(negedge clk);
      chk(n_rd == rd0 && !tx_active, "R8", "zero count no access", 128'(n_rd - rd0), 128'd0);

      // R9: active rewrite ignored
      ri0 = n_rxi; wr0 = n_wr;
      rxq_a.push_back(16'd120); rxq_d.push_back(rxpat(30));
      rxq_a.push_back(16'd121); rxq_d.push_back(rxpat(31));
      rxq_a.push_back(16'd122); rxq_d.push_back(rxpat(32));
      load(1, mk(120, 3, 1, 0, 1, 1));
      load(1, mk(150, 6, 3, 0, 1, 0));
      chk(rx_active, "R9", "still active after rewrite", 128'(rx_active), 128'd1);
      feedq.push_back(rxpat(30)); feedq.push_back(rxpat(31)); feedq.push_back(rxpat(32));
      wait_idle("R9");
      chk(n_wr - wr0 == 3, "R9", "original count kept", 128'(n_wr - wr0), 128'd3);
      chk(n_rxi - ri0 == 1, "R9", "original irq enable kept", 128'(n_rxi - ri0), 128'd1);

      // R10: stop mid-stream
      ri0 = n_rxi;
      push_rx(170, 2, 1, 40);
      load(1, mk(170, 5, 1, 0, 1, 1));
      wait_idle_part();
      load(1, mk(0, 0, 0, 0, 0, 0));
      chk(!rx_active, "R10", "stopped", 128'(rx_active), 128'd0);
      wr0 = n_wr;
      feedq.push_back(rxpat(50));
      repeat (10) @(negedge clk);
      chk(rxb_valid && n_wr == wr0, "R10", "no write after stop", 128'(n_wr - wr0), 128'd0);
      chk(n_rxi == ri0, "R10", "no irq after stop", 128'(n_rxi - ri0), 128'd0);
      rxq_a.push_back(16'd200); rxq_d.push_back(rxpat(50));
      load(1, mk(200, 1, 1, 0, 1, 0));
      wait_idle("R10");
      chk(mem[200] == rxpat(50), "R10", "held word later written", mem[200], rxpat(50));

      // R11: second-dimension count refused
      rd0 = n_rd;
      load(0, mk(8, 2, 1, 1, 1, 1));
      repeat (10) @(negedge clk);
      chk(!tx_active && n_rd == rd0, "R11", "2-D descriptor refused", 128'(n_rd - rd0), 128'd0);

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wait_idle_part();
      int n = 0;
      while (rxq_d.size() > 0 && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(n < 2000, "R10", "partial stream did not land", 128'(n), 128'd0);
   endtask
endmodule